// File: doc/BRIEF.md
# Stop-Mode Wakeup Delay Controller

This block governs a processor core's low-power stop state and the way back out of it. When the core requests a stop, the block lets the stop operation run its fixed length in T cycles with all clocks still on. It then either shuts the clock generator off or, if the external interrupt line is already active, only gates the core phase clock. In both cases it then counts a stabilization delay whose length a select bit picks. At the end of that delay it issues a one-cycle wakeup strobe that starts the vector fetch.

T cycles are marked by a `tick` enable from the oscillator side. Every counter advances only on a tick.

Two kinds of interrupt are tracked during the sequence. An edge-triggered interrupt that shows up while the delay is counting is dropped. A pending stack-error interrupt is kept through the whole sequence.

Reset (synchronous, active high) wins over every other input. It returns the block to normal running with the clocks on and no delay. It clears the pending flags. It arms a one-time path: a short assertion of the interrupt line after reset runs the programmed delay.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After a stop request with the synchronized interrupt inactive, `core_clk_en` and `clkgen_en` stay high for exactly 32 T cycles. The block then enters the stopped state, where both are low until `irq_n` goes low.
- R2: When `irq_n` goes low in the stopped state, `clkgen_en` returns high. `core_clk_en` stays low for a delay of 16 T cycles when the latched select is 1.
- R3: With a latched select of 0, the delay lasts 131,072 T cycles.
- R4: At the end of the delay, `wake_strobe` is high for exactly one cycle, with `core_clk_en` high. The strobe is low again in the next cycle.
- R5: `delay_sel` is captured when the stop request is accepted. Changing it later in the sequence does not alter the delay length.
- R6: If the interrupt line, after its 3 T-cycle synchronizer, is active when the stop request is accepted, the 32-cycle entry still runs. `clkgen_en` then never goes low, and only `core_clk_en` is gated for the delay count.
- R7: An `edge_irq` pulse outside the delay sets `edge_pend` (high = pending) until `edge_ack`. During the delay, `edge_pend` is cleared and `edge_irq` pulses are ignored.
- R8: `stk_pend`, once set by `stk_err`, stays high through stop, delay and wakeup until `stk_ack`.
- R9: Reset in any state returns the block to running in the next cycle. After reset, `core_clk_en` and `clkgen_en` are high, `edge_pend` and `stk_pend` are low, and no wakeup strobe follows.
- R10: After reset, the first assertion of `irq_n` (low for about two T cycles) while running starts the programmed delay. During it `core_clk_en` is low, and it ends with a wakeup strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, highest priority |
| tick | input | 1 | One T cycle elapsed |
| stop_req | input | 1 | Stop request from the core |
| irq_n | input | 1 | External interrupt, active low |
| delay_sel | input | 1 | 1 = short 16 T delay, 0 = long 131,072 T delay |
| edge_irq | input | 1 | Edge-triggered interrupt event pulse |
| edge_ack | input | 1 | Clears `edge_pend` |
| stk_err | input | 1 | Stack-error interrupt event pulse |
| stk_ack | input | 1 | Clears `stk_pend` |
| clkgen_en | output | 1 | Clock generator enable |
| core_clk_en | output | 1 | Core phase-clock enable |
| wake_strobe | output | 1 | One-cycle wakeup / vector-fetch strobe |
| edge_pend | output | 1 | Edge-triggered interrupt pending |
| stk_pend | output | 1 | Stack-error interrupt pending |

## Verification
The checks assume that `stop_req` is a single-cycle pulse raised only while the core is running. They also assume that `stk_ack` and `stk_err` never coincide, and that in the normal (non-no-op) case `irq_n` stays high until the stopped state is reached. The stimulus keeps `tick` high so that T cycles and clock cycles coincide. It pulses each request or acknowledge for one cycle, and it holds `irq_n` at its level for at least five cycles before each stop request, so the synchronizer has settled when the request is sampled.

// File: rtl/swk_pkg.sv
package swk_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_ENTRY   = 3'd1,
        ST_STOPPED = 3'd2,
        ST_DELAY   = 3'd3,
        ST_WAKE    = 3'd4
    } swk_state_e;

    localparam int unsigned SWK_DLY_LONG  = 131072;
    localparam int unsigned SWK_DLY_SHORT = 16;
    localparam int unsigned SWK_ENTRY_T   = 32;
    localparam int unsigned SWK_SYNC_T    = 3;

    function automatic logic core_on(input swk_state_e s);
        return (s == ST_RUN) || (s == ST_ENTRY) || (s == ST_WAKE);
    endfunction

    function automatic logic osc_on(input swk_state_e s);
        return s != ST_STOPPED;
    endfunction

endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst)       stg <= '0;
        else if (tick) stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/swk_tcount.sv
module swk_tcount #(
    parameter int unsigned W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] term,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (en)    cnt <= cnt + 1'b1;
    end

    assign hit = en && (cnt == term);
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
    import swk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       stop_req,
    input  logic       irq_n,
    input  logic       irq_sync,
    input  logic       delay_sel,
    input  logic       ent_hit,
    input  logic       dly_hit,
    output swk_state_e state,
    output logic       sel_q
);
    logic nop_q;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            sel_q <= 1'b0;
            nop_q <= 1'b0;
            armed <= 1'b1;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (stop_req) begin
                        state <= ST_ENTRY;
                        sel_q <= delay_sel;
                        nop_q <= irq_sync;
                        armed <= 1'b0;
                    end else if (armed && irq_sync) begin
                        state <= ST_DELAY;
                        sel_q <= delay_sel;
                        nop_q <= 1'b1;
                        armed <= 1'b0;
                    end
                end
                ST_ENTRY: begin
                    if (ent_hit) state <= nop_q ? ST_DELAY : ST_STOPPED;
                end
                ST_STOPPED: begin
                    if (!irq_n) state <= ST_DELAY;
                end
                ST_DELAY: begin
                    if (dly_hit) state <= ST_WAKE;
                end
                ST_WAKE: begin
                    if (tick) state <= ST_RUN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swk_pkg::*;
#(
    parameter int unsigned DLY_LONG  = SWK_DLY_LONG,
    parameter int unsigned DLY_SHORT = SWK_DLY_SHORT,
    parameter int unsigned ENTRY_T   = SWK_ENTRY_T,
    parameter int unsigned SYNC_T    = SWK_SYNC_T
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic stop_req,
    input  logic irq_n,
    input  logic delay_sel,
    input  logic edge_irq,
    input  logic edge_ack,
    input  logic stk_err,
    input  logic stk_ack,
    output logic clkgen_en,
    output logic core_clk_en,
    output logic wake_strobe,
    output logic edge_pend,
    output logic stk_pend
);
    localparam int unsigned CNT_W = $clog2(DLY_LONG);
    localparam int unsigned ENT_W = $clog2(ENTRY_T);
    localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(DLY_LONG - 1);
    localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(DLY_SHORT - 1);
    localparam logic [ENT_W-1:0] T_ENTRY = ENT_W'(ENTRY_T - 1);

    swk_state_e       state;
    logic             sel_q;
    logic             irq_sync;
    logic             ent_hit;
    logic             dly_hit;
    logic [CNT_W-1:0] dly_term;

    assign dly_term = sel_q ? T_SHORT : T_LONG;

    swk_sync #(.STAGES(SYNC_T)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .d    (~irq_n),
        .q    (irq_sync)
    );

    swk_tcount #(.W(ENT_W)) u_ent (
        .clk  (clk),
        .rst  (rst),
        .clr  (state != ST_ENTRY),
        .en   (tick && (state == ST_ENTRY)),
        .term (T_ENTRY),
        .hit  (ent_hit)
    );

    swk_tcount #(.W(CNT_W)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .clr  (state != ST_DELAY),
        .en   (tick && (state == ST_DELAY)),
        .term (dly_term),
        .hit  (dly_hit)
    );

    swk_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .stop_req  (stop_req),
        .irq_n     (irq_n),
        .irq_sync  (irq_sync),
        .delay_sel (delay_sel),
        .ent_hit   (ent_hit),
        .dly_hit   (dly_hit),
        .state     (state),
        .sel_q     (sel_q)
    );

    assign clkgen_en   = osc_on(state);
    assign core_clk_en = core_on(state);
    assign wake_strobe = (state == ST_WAKE) && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_pend <= 1'b0;
            stk_pend  <= 1'b0;
        end else begin
            if (state == ST_DELAY) edge_pend <= 1'b0;
            else if (edge_irq)     edge_pend <= 1'b1;
            else if (edge_ack)     edge_pend <= 1'b0;

            if (stk_err)      stk_pend <= 1'b1;
            else if (stk_ack) stk_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/swk_checker.sv
module swk_checker
    import swk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input swk_state_e state,
    input logic       sel_q,
    input logic       clkgen_en,
    input logic       core_clk_en,
    input logic       wake_strobe,
    input logic       edge_pend,
    input logic       stk_pend,
    input logic       stk_ack
);
    p_stopped_gated_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOPPED) |-> (!clkgen_en && !core_clk_en));

    p_wake_after_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && $past(state) != ST_WAKE) |-> ($past(state) == ST_DELAY));

    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wake_strobe |=> !wake_strobe);

    p_strobe_clocks_r4: assert property (@(posedge clk) disable iff (rst)
        wake_strobe |-> (core_clk_en && clkgen_en));

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN && $past(state) != ST_RUN) |-> $stable(sel_q));

    p_delay_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY) |=> !edge_pend);

    p_stk_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (stk_pend && !stk_ack) |=> stk_pend);

    p_reset_run_r9: assert property (@(posedge clk)
        rst |=> (state == ST_RUN && !edge_pend && !stk_pend));
endmodule

bind stop_wake_ctrl swk_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .sel_q       (sel_q),
    .clkgen_en   (clkgen_en),
    .core_clk_en (core_clk_en),
    .wake_strobe (wake_strobe),
    .edge_pend   (edge_pend),
    .stk_pend    (stk_pend),
    .stk_ack     (stk_ack)
);

// File: tb/sim_stop_wake_ctrl.sv
`timescale 1ns/1ps
module sim_stop_wake_ctrl;
    logic clk = 1'b0;
    logic rst, tick, stop_req, irq_n, delay_sel;
    logic edge_irq, edge_ack, stk_err, stk_ack;
    logic clkgen_en, core_clk_en, wake_strobe, edge_pend, stk_pend;

    int checks   = 0;
    int failures = 0;

    localparam int NROWS = 3;
    localparam bit          ROW_SEL [NROWS] = '{1'b1, 1'b1, 1'b0};
    localparam bit          ROW_PRE [NROWS] = '{1'b0, 1'b1, 1'b0};
    localparam int unsigned ROW_EXP [NROWS] = '{16, 16, 131072};

    always #10 clk = ~clk;

    stop_wake_ctrl u0 (
        .clk(clk), .rst(rst), .tick(tick), .stop_req(stop_req), .irq_n(irq_n),
        .delay_sel(delay_sel), .edge_irq(edge_irq), .edge_ack(edge_ack),
        .stk_err(stk_err), .stk_ack(stk_ack), .clkgen_en(clkgen_en),
        .core_clk_en(core_clk_en), .wake_strobe(wake_strobe),
        .edge_pend(edge_pend), .stk_pend(stk_pend)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_row(input bit sel, input bit pre, input int unsigned exp);
        int n;
        int g;
        int off;
        irq_n = pre ? 1'b0 : 1'b1;
        delay_sel = sel;
        repeat (5) @(negedge clk);
        stk_err = 1'b1;
        @(negedge clk) stk_err = 1'b0;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        delay_sel = !sel;
        n = 0;
        while (core_clk_en && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 32, "R1 entry length", n, 32);
        if (!pre) begin
            chk(!clkgen_en, "R1 clock generator off", clkgen_en, 0);
            repeat (3) @(negedge clk);
            chk(!clkgen_en && !core_clk_en, "R1 stays stopped", clkgen_en, 0);
            irq_n = 1'b0;
            @(negedge clk);
        end else begin
            chk(clkgen_en, "R6 clock generator kept on", clkgen_en, 1);
        end
        g = 0;
        off = 0;
        while (!core_clk_en && g < 140000) begin
            if (!clkgen_en) off++;
            g++;
            edge_irq = (g == 3);
            @(negedge clk);
        end
        edge_irq = 1'b0;
        if (sel) chk(g == int'(exp), "R2 R5 short delay length", g, exp);
        else     chk(g == int'(exp), "R3 R5 long delay length", g, exp);
        if (pre) chk(off == 0, "R6 no clock-generator stop", off, 0);
        else     chk(off == 0, "R2 clock generator on in delay", off, 0);
        chk(wake_strobe && core_clk_en, "R4 strobe at wake", wake_strobe, 1);
        @(negedge clk);
        chk(!wake_strobe, "R4 strobe one cycle", wake_strobe, 0);
        chk(!edge_pend, "R7 edge irq ignored in delay", edge_pend, 0);
        chk(stk_pend, "R8 stack error kept", stk_pend, 1);
        stk_ack = 1'b1;
        @(negedge clk) stk_ack = 1'b0;
        irq_n = 1'b1;
        delay_sel = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic post_reset_irq(input string tag);
        int n;
        int g;
        delay_sel = 1'b1;
        irq_n = 1'b0;
        repeat (2) @(negedge clk);
        irq_n = 1'b1;
        n = 0;
        while (core_clk_en && n < 20) begin
            n++;
            @(negedge clk);
        end
        g = 0;
        while (!core_clk_en && g < 100) begin
            g++;
            @(negedge clk);
        end
        chk(g == 16, {tag, " delay after irq pulse"}, g, 16);
        chk(wake_strobe, {tag, " strobe after delay"}, wake_strobe, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int s;
        rst = 1'b1; tick = 1'b1; stop_req = 1'b0; irq_n = 1'b1; delay_sel = 1'b0;
        edge_irq = 1'b0; edge_ack = 1'b0; stk_err = 1'b0; stk_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(core_clk_en && clkgen_en && !wake_strobe, "R9 reset state clocks", core_clk_en, 1);
        chk(!edge_pend && !stk_pend, "R9 reset state pending", edge_pend + stk_pend, 0);

        for (int i = 0; i < NROWS; i++) run_row(ROW_SEL[i], ROW_PRE[i], ROW_EXP[i]);

        // R7: edge irq latched outside the delay, released by ack
        edge_irq = 1'b1;
        @(negedge clk) edge_irq = 1'b0;
        chk(edge_pend, "R7 edge irq latched", edge_pend, 1);
        edge_ack = 1'b1;
        @(negedge clk) edge_ack = 1'b0;
        chk(!edge_pend, "R7 edge ack clears", edge_pend, 0);

        // R9: reset while stopped
        stk_err = 1'b1;
        @(negedge clk) stk_err = 1'b0;
        delay_sel = 1'b1;
        stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
        repeat (40) @(negedge clk);
        chk(!clkgen_en, "R9 precondition stopped", clkgen_en, 0);
        edge_irq = 1'b1;
        @(negedge clk) edge_irq = 1'b0;
        chk(edge_pend, "R7 edge irq latched while stopped", edge_pend, 1);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk(core_clk_en && clkgen_en && !wake_strobe, "R9 reset leaves stop at once", core_clk_en, 1);
        chk(!edge_pend && !stk_pend, "R9 reset discards pending", edge_pend + stk_pend, 0);

        // R10: armed delay after reset
        post_reset_irq("R10");
        @(negedge clk);
        chk(core_clk_en && !wake_strobe, "R10 back to running", core_clk_en, 1);

        // R9: reset during the delay suppresses the wakeup strobe
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        delay_sel = 1'b1;
        irq_n = 1'b0;
        repeat (2) @(negedge clk);
        irq_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!core_clk_en, "R10 delay started again", core_clk_en, 0);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        s = 0;
        for (int k = 0; k < 30; k++) begin
            if (wake_strobe || !core_clk_en) s++;
            @(negedge clk);
        end
        chk(s == 0, "R9 no strobe after reset in delay", s, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule